// File: doc/BRIEF.md
# SPI Word-Packed Data FIFO Port

This block sits between a 32-bit register port and a byte-wide serial shifter. Software writes whole 32-bit words to a transmit data register. The block stores them in a transmit FIFO of 32 bytes and hands them to the shifter one byte at a time. Bytes that the shifter receives are gathered four to a word in a receive FIFO of the same size. Software drains that FIFO one word per read of the receive data register.

A transfer is opened with a start pulse and a byte count from 0 to 32. The count sets how many bytes the shifter may take and how many it may return. When the count is not a multiple of four, the last word is partial on both paths: unused transmit lanes are thrown away, and missing receive lanes read as zero.

A per-direction swap input reverses the byte order within each word on that path. Two sticky error flags, for transmit overflow and receive underflow, are cleared only by reset or by the soft-clear input.

Top module: `spi_word_port`

## Requirements
- R1: A write at address 0x10 pushes the write data into the transmit FIFO. A write at any other address has no effect. A read at address 0x14 pops the receive FIFO and shows the word on `bus_rdata` in the following cycle. A read at any other address returns zero there and pops nothing.
- R2: With `tx_swap` low, byte i of a transfer is bits [8*(i mod 4)+7 : 8*(i mod 4)] of transmit word floor(i/4), and bytes leave lowest lane first.
- R3: The transmit FIFO holds 8 words. A write while it is full is dropped, and `tx_ovf` goes high the next cycle and stays high.
- R4: After `xfer_len` bytes have been taken, `tx_byte_valid` is low. The unused lanes of a partial last word are discarded, so the next transfer starts at lane 0 of the next word.
- R5: With `rx_swap` low, received byte i is placed in lane (i mod 4) of its word, and the word enters the receive FIFO after its fourth byte.
- R6: The last byte of a transfer pushes a partial word whose missing lanes are zero. Once `xfer_len` bytes have arrived, `rx_byte_ready` is low.
- R7: A read of 0x14 while the receive FIFO is empty returns zero and sets the sticky flag `rx_udf`.
- R8: With `tx_swap` high, byte i is taken from lane 3-(i mod 4).
- R9: With `rx_swap` high, received byte i is placed in lane 3-(i mod 4).
- R10: A `soft_clr` pulse empties both FIFOs, clears both flags and ends the open transfer.
- R11: After reset, both flags are low, `tx_byte_valid` and `rx_byte_ready` are low, and `bus_rdata` is zero.
- R12: While `tx_byte_valid` is high and `tx_byte_take` is low, `tx_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Empties the FIFOs, clears the flags and ends the transfer |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| tx_swap | input | 1 | Reverse the byte order within each transmit word |
| rx_swap | input | 1 | Reverse the byte order within each receive word |
| xfer_start | input | 1 | Opens a transfer and loads its length |
| xfer_len | input | LEN_W | Transfer length in bytes, 0 to 32 |
| tx_byte_valid | output | 1 | A transmit byte is offered |
| tx_byte | output | 8 | Offered transmit byte |
| tx_byte_take | input | 1 | The shifter takes the offered byte |
| rx_byte_valid | input | 1 | The shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_byte_ready | output | 1 | The block can accept a received byte |
| tx_ovf | output | 1 | Sticky flag: a transmit write was dropped |
| rx_udf | output | 1 | Sticky flag: the receive FIFO was read while empty |

## Verification
The assertions check several behaviours on every cycle. A write to a full transmit FIFO raises the overflow flag. A read of an empty receive FIFO returns zero and raises the underflow flag. Both flags stay set until a clear, a clear leaves both flags low with no byte offered, and an offered transmit byte holds until it is taken. The directed scenarios alone show the lane order with and without the swap, where partial words start and stop, and how stray addresses are ignored, because those depend on the sequence of words and bytes across a whole transfer.

// File: rtl/spi_wpk_pkg.sv
package spi_wpk_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [1:0]        lane_t;

    // Kind of register read seen on the bus this cycle
    typedef enum logic [1:0] {
        RD_NONE,
        RD_POP,
        RD_EMPTY,
        RD_STRAY
    } rd_kind_e;

    // Lane that holds the byte at offset off within its word
    function automatic lane_t lane_of(lane_t off, logic swap);
        return swap ? lane_t'(2'd3 - off) : off;
    endfunction

    function automatic byte_t lane_get(word_t w, lane_t l);
        return w[{l, 3'b000} +: BYTE_W];
    endfunction
endpackage

// File: rtl/spi_wpk_word_fifo.sv
module spi_wpk_word_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W:0]   wr_ptr;
    logic [PTR_W:0]   rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[PTR_W] != rd_ptr[PTR_W]) &&
                     (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr[PTR_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !rst && !clr) mem[wr_ptr[PTR_W-1:0]] <= push_data;
    end
endmodule

// File: rtl/spi_wpk_tx_unpack.sv
module spi_wpk_tx_unpack
    import spi_wpk_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             swap,
    input  word_t            head,
    input  logic             empty,
    input  logic             take,
    output logic             pop,
    output logic             byte_valid,
    output byte_t            byte_out
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    lane_t            off_q;
    logic             active;
    logic             fire;
    logic             last;

    assign active     = (cnt_q < len_q);
    assign byte_valid = active && !empty;
    assign byte_out   = lane_get(head, lane_of(off_q, swap));
    assign fire       = byte_valid && take;
    assign last       = ((cnt_q + LEN_W'(1)) == len_q);
    // A word leaves after its fourth lane or the transfer's last byte
    assign pop        = fire && ((off_q == 2'd3) || last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            len_q <= '0;
            cnt_q <= '0;
            off_q <= '0;
        end else if (start) begin
            len_q <= len;
            cnt_q <= '0;
            off_q <= '0;
        end else if (fire) begin
            cnt_q <= cnt_q + LEN_W'(1);
            off_q <= pop ? 2'd0 : off_q + 2'd1;
        end
    end
endmodule

// File: rtl/spi_wpk_rx_pack.sv
module spi_wpk_rx_pack
    import spi_wpk_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             swap,
    input  logic             in_valid,
    input  byte_t            in_byte,
    input  logic             full,
    output logic             ready,
    output logic             push,
    output word_t            push_word
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    lane_t            off_q;
    word_t            acc_q;
    word_t            merged;
    lane_t            lane;
    logic             fire;
    logic             last;

    assign lane  = lane_of(off_q, swap);
    assign ready = (cnt_q < len_q) && !full;
    assign fire  = in_valid && ready;
    assign last  = ((cnt_q + LEN_W'(1)) == len_q);
    assign push  = fire && ((off_q == 2'd3) || last);
    assign push_word = merged;

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign merged[g*BYTE_W +: BYTE_W] =
            (lane == lane_t'(g)) ? in_byte : acc_q[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            len_q <= '0;
            cnt_q <= '0;
            off_q <= '0;
            acc_q <= '0;
        end else if (start) begin
            len_q <= len;
            cnt_q <= '0;
            off_q <= '0;
            acc_q <= '0;
        end else if (fire) begin
            cnt_q <= cnt_q + LEN_W'(1);
            off_q <= push ? 2'd0 : off_q + 2'd1;
            acc_q <= push ? '0 : merged;
        end
    end
endmodule

// File: rtl/spi_word_port.sv
module spi_word_port
    import spi_wpk_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] TX_OFS   = 'h10,
    parameter logic [ADDR_W-1:0] RX_OFS   = 'h14,
    parameter int              FIFO_BYTES = 32,
    parameter int              LEN_W      = $clog2(FIFO_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tx_swap,
    input  logic              rx_swap,
    input  logic              xfer_start,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              tx_byte_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_byte_take,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_byte_ready,
    output logic              tx_ovf,
    output logic              rx_udf
);
    localparam int DEPTH = FIFO_BYTES / WORD_BYTES;

    word_t    tx_head;
    logic     tx_full;
    logic     tx_empty;
    logic     tx_pop;
    logic     tx_push;
    word_t    rx_head;
    logic     rx_full;
    logic     rx_empty;
    logic     rx_push;
    word_t    rx_word;
    rd_kind_e rd_kind;

    assign tx_push = bus_wr && (bus_addr == TX_OFS);

    always_comb begin
        rd_kind = RD_NONE;
        if (bus_rd) begin
            if (bus_addr == RX_OFS) rd_kind = rx_empty ? RD_EMPTY : RD_POP;
            else                    rd_kind = RD_STRAY;
        end
    end

    spi_wpk_word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) tx_fifo_i (
        .clk(clk), .rst(rst), .clr(soft_clr),
        .push(tx_push), .push_data(bus_wdata), .pop(tx_pop),
        .head(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_wpk_tx_unpack #(.LEN_W(LEN_W)) tx_unpack_i (
        .clk(clk), .rst(rst), .clr(soft_clr),
        .start(xfer_start), .len(xfer_len), .swap(tx_swap),
        .head(tx_head), .empty(tx_empty), .take(tx_byte_take),
        .pop(tx_pop), .byte_valid(tx_byte_valid), .byte_out(tx_byte)
    );

    spi_wpk_rx_pack #(.LEN_W(LEN_W)) rx_pack_i (
        .clk(clk), .rst(rst), .clr(soft_clr),
        .start(xfer_start), .len(xfer_len), .swap(rx_swap),
        .in_valid(rx_byte_valid), .in_byte(rx_byte), .full(rx_full),
        .ready(rx_byte_ready), .push(rx_push), .push_word(rx_word)
    );

    spi_wpk_word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) rx_fifo_i (
        .clk(clk), .rst(rst), .clr(soft_clr),
        .push(rx_push), .push_data(rx_word), .pop(rd_kind == RD_POP),
        .head(rx_head), .full(rx_full), .empty(rx_empty)
    );

    // Registered read data and sticky error flags
    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            bus_rdata <= '0;
            tx_ovf    <= 1'b0;
            rx_udf    <= 1'b0;
        end else begin
            unique case (rd_kind)
                RD_POP:   bus_rdata <= rx_head;
                RD_EMPTY: begin
                    bus_rdata <= '0;
                    rx_udf    <= 1'b1;
                end
                RD_STRAY: bus_rdata <= '0;
                default:  ;
            endcase
            if (tx_push && tx_full) tx_ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_word_port_chk.sv
module spi_word_port_chk #(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] TX_OFS = 'h10,
    parameter logic [ADDR_W-1:0] RX_OFS = 'h14
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_clr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              tx_ovf,
    input logic              rx_udf,
    input logic              tx_byte_valid,
    input logic [7:0]        tx_byte,
    input logic              tx_byte_take,
    input logic              tx_swap,
    input logic              xfer_start
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == TX_OFS && tx_full && !soft_clr) |=> tx_ovf);

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_ovf && !soft_clr) |=> tx_ovf);

    assert_underflow_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == RX_OFS && rx_empty && !soft_clr)
        |=> (rx_udf && bus_rdata == 32'h0));

    assert_udf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_udf && !soft_clr) |=> rx_udf);

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (!tx_ovf && !rx_udf && !tx_byte_valid));

    assert_byte_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (tx_byte_valid && !tx_byte_take && !xfer_start && !soft_clr)
        |=> ((tx_byte_valid && tx_byte == $past(tx_byte)) || tx_swap != $past(tx_swap)));
endmodule

bind spi_word_port spi_word_port_chk #(
    .ADDR_W(ADDR_W), .TX_OFS(TX_OFS), .RX_OFS(RX_OFS)
) chk_i (
    .clk(clk), .rst(rst), .soft_clr(soft_clr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .tx_full(tx_full), .rx_empty(rx_empty),
    .tx_ovf(tx_ovf), .rx_udf(rx_udf), .tx_byte_valid(tx_byte_valid),
    .tx_byte(tx_byte), .tx_byte_take(tx_byte_take), .tx_swap(tx_swap),
    .xfer_start(xfer_start)
);

// File: tb/spi_word_port_tb_top.sv
`timescale 1ns/1ps
module spi_word_port_tb_top;
    localparam logic [7:0] TXA = 8'h10;
    localparam logic [7:0] RXA = 8'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_clr = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_swap = 1'b0;
    logic        rx_swap = 1'b0;
    logic        xfer_start = 1'b0;
    logic [5:0]  xfer_len = '0;
    logic        tx_byte_valid;
    logic [7:0]  tx_byte;
    logic        tx_byte_take = 1'b0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_byte_ready;
    logic        tx_ovf;
    logic        rx_udf;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spi_word_port dut_i (
        .clk(clk), .rst(rst), .soft_clr(soft_clr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_swap(tx_swap), .rx_swap(rx_swap),
        .xfer_start(xfer_start), .xfer_len(xfer_len),
        .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte), .tx_byte_take(tx_byte_take),
        .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_byte_ready(rx_byte_ready),
        .tx_ovf(tx_ovf), .rx_udf(rx_udf)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Every task starts and ends just after a falling edge
    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic start(int len);
        xfer_start = 1'b1; xfer_len = 6'(len);
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic pulse_clear();
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
    endtask

    task automatic take_byte(string req, logic [7:0] exp);
        chk({req, " valid"}, 32'(tx_byte_valid), 32'd1);
        chk({req, " byte"}, 32'(tx_byte), 32'(exp));
        tx_byte_take = 1'b1;
        @(negedge clk);
        tx_byte_take = 1'b0;
    endtask

    task automatic push_rx(string req, logic [7:0] b);
        chk({req, " ready"}, 32'(rx_byte_ready), 32'd1);
        rx_byte_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_byte_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 tx_ovf", 32'(tx_ovf), 0);
        chk("R11 rx_udf", 32'(rx_udf), 0);
        chk("R11 tx_byte_valid", 32'(tx_byte_valid), 0);
        chk("R11 rx_byte_ready", 32'(rx_byte_ready), 0);
        chk("R11 bus_rdata", bus_rdata, 0);
    endtask

    task automatic t_tx_order();
        pulse_clear();
        start(8);
        bus_write(TXA, 32'h44332211);
        bus_write(TXA, 32'h88776655);
        for (int i = 0; i < 8; i++) take_byte("R2", 8'((i + 1) * 8'h11));
        chk("R4 valid low at end", 32'(tx_byte_valid), 0);
    endtask

    task automatic t_tx_partial();
        pulse_clear();
        start(6);
        bus_write(TXA, 32'hA3A2A1A0);
        bus_write(TXA, 32'hB3B2B1B0);
        bus_write(TXA, 32'hC3C2C1C0);
        for (int i = 0; i < 4; i++) take_byte("R4 word0", 8'(8'hA0 + i));
        take_byte("R4 word1", 8'hB0);
        take_byte("R4 word1", 8'hB1);
        chk("R4 valid low after 6", 32'(tx_byte_valid), 0);
        start(4);
        for (int i = 0; i < 4; i++) take_byte("R4 next word", 8'(8'hC0 + i));
    endtask

    task automatic t_tx_swap();
        pulse_clear();
        tx_swap = 1'b1;
        start(6);
        bus_write(TXA, 32'h44332211);
        bus_write(TXA, 32'h88776655);
        take_byte("R8", 8'h44); take_byte("R8", 8'h33);
        take_byte("R8", 8'h22); take_byte("R8", 8'h11);
        take_byte("R8 partial", 8'h88); take_byte("R8 partial", 8'h77);
        tx_swap = 1'b0;
    endtask

    task automatic t_tx_hold();
        pulse_clear();
        start(1);
        bus_write(TXA, 32'h000000AB);
        for (int i = 0; i < 3; i++) begin
            chk("R12 hold valid", 32'(tx_byte_valid), 1);
            chk("R12 hold byte", 32'(tx_byte), 32'hAB);
            @(negedge clk);
        end
        take_byte("R12", 8'hAB);
        chk("R12 gone", 32'(tx_byte_valid), 0);
    endtask

    task automatic t_tx_overflow();
        pulse_clear();
        start(32);
        for (int k = 0; k < 8; k++)
            bus_write(TXA, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
        chk("R3 no ovf at 8 words", 32'(tx_ovf), 0);
        bus_write(TXA, 32'hDEADBEEF);
        chk("R3 ovf set", 32'(tx_ovf), 1);
        for (int i = 0; i < 32; i++) take_byte("R3 contents", 8'(i));
        chk("R3 dropped word absent", 32'(tx_byte_valid), 0);
        chk("R3 ovf sticky", 32'(tx_ovf), 1);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        pulse_clear();
        bus_write(8'h18, 32'h12345678);
        start(4);
        chk("R1 stray write ignored", 32'(tx_byte_valid), 0);
        push_rx("R1", 8'h01); push_rx("R1", 8'h02);
        push_rx("R1", 8'h03); push_rx("R1", 8'h04);
        bus_read(TXA, d);
        chk("R1 stray read zero", d, 0);
        chk("R1 stray read no udf", 32'(rx_udf), 0);
        bus_read(RXA, d);
        chk("R1 read pops", d, 32'h04030201);
        bus_read(RXA, d);
        chk("R1 fifo now empty", d, 0);
    endtask

    task automatic t_rx_pack();
        logic [31:0] d;
        pulse_clear();
        start(4);
        push_rx("R5", 8'h11); push_rx("R5", 8'h22);
        push_rx("R5", 8'h33); push_rx("R5", 8'h44);
        chk("R6 ready low after len", 32'(rx_byte_ready), 0);
        bus_read(RXA, d);
        chk("R5 word", d, 32'h44332211);
        start(7);
        for (int i = 1; i <= 7; i++) push_rx("R6", 8'(i));
        bus_read(RXA, d);
        chk("R5 full word", d, 32'h04030201);
        bus_read(RXA, d);
        chk("R6 partial word", d, 32'h00070605);
        chk("R6 no udf", 32'(rx_udf), 0);
    endtask

    task automatic t_rx_swap();
        logic [31:0] d;
        pulse_clear();
        rx_swap = 1'b1;
        start(4);
        push_rx("R9", 8'h11); push_rx("R9", 8'h22);
        push_rx("R9", 8'h33); push_rx("R9", 8'h44);
        bus_read(RXA, d);
        chk("R9 word", d, 32'h11223344);
        start(2);
        push_rx("R9", 8'hAA); push_rx("R9", 8'hBB);
        bus_read(RXA, d);
        chk("R9 partial", d, 32'hAABB0000);
        rx_swap = 1'b0;
    endtask

    task automatic t_underflow();
        logic [31:0] d;
        pulse_clear();
        bus_read(RXA, d);
        chk("R7 empty read zero", d, 0);
        chk("R7 udf set", 32'(rx_udf), 1);
        start(4);
        push_rx("R7", 8'h5A); push_rx("R7", 8'h6B);
        push_rx("R7", 8'h7C); push_rx("R7", 8'h8D);
        bus_read(RXA, d);
        chk("R7 later read", d, 32'h8D7C6B5A);
        chk("R7 udf sticky", 32'(rx_udf), 1);
    endtask

    task automatic t_soft_clear();
        logic [31:0] d;
        start(8);
        bus_write(TXA, 32'h11111111);
        for (int k = 0; k < 8; k++) bus_write(TXA, 32'h22222222);
        push_rx("R10", 8'h01); push_rx("R10", 8'h02);
        push_rx("R10", 8'h03); push_rx("R10", 8'h04);
        chk("R10 pre ovf", 32'(tx_ovf), 1);
        chk("R10 pre valid", 32'(tx_byte_valid), 1);
        pulse_clear();
        chk("R10 ovf cleared", 32'(tx_ovf), 0);
        chk("R10 udf cleared", 32'(rx_udf), 0);
        chk("R10 transfer ended", 32'(tx_byte_valid), 0);
        start(4);
        chk("R10 tx fifo emptied", 32'(tx_byte_valid), 0);
        bus_read(RXA, d);
        chk("R10 rx fifo emptied", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_order();
        t_tx_partial();
        t_tx_swap();
        t_tx_hold();
        t_tx_overflow();
        t_decode();
        t_rx_pack();
        t_rx_swap();
        t_underflow();
        t_soft_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule